// File: doc/BRIEF.md
# RSSI threshold event generator

This block watches the received-signal-strength codes of a radio receiver and turns them into status events. A single programmable threshold is shared by four functions: a sticky interrupt flag, a live clear-channel indication, a remembered clear-channel indication, and a squelch gate on the demodulated data. All of these use only the current (per-bit-period) strength sample. The latched strength sample is used only by an optional weak-channel check. When that check fails, the block emits a one-cycle invalid-preamble pulse, which the receive sequencer uses to jump to its timeout state, for example to move a hopping receiver to its next channel.

The current sample is compared only when its update strobe is present, and the result is held between strobes. A value equal to the threshold counts as below it. When the receiver is switched off, all status flags drop.

Top module: `rssi_event_gen`

## Requirements
- R1: On a clock edge where `rx_on` and `cur_stb` are high, `cca` takes the value (`cur_rssi` > `thresh`), unsigned and strict, and shows it from that edge on. A sample equal to the threshold gives `cca` = 0.
- R2: While no `cur_stb` arrives and `rx_on` stays high, `cca` holds its value whatever `cur_rssi` does.
- R3: A strobed current sample above the threshold sets `irq_flag` at that edge. This happens regardless of `chk_at_latch_en`, `lat_rssi` and `lat_stb`.
- R4: `irq_flag` stays set until an `irq_clr` or `rx_restart` pulse. If a set condition and a clear pulse arrive in the same cycle, the flag stays set.
- R5: `cca_latched` is set by the same above-threshold sample that raises `cca`, and stays set after `cca` falls. It is cleared only by `sync_det` or `rx_restart`, which win over a simultaneous set. `irq_clr` has no effect on it.
- R6: With `chk_at_latch_en` high, a `lat_stb` whose `lat_rssi` is strictly below `thresh` yields `inv_preamble` high for exactly the cycle after that edge. If `lat_rssi` ≥ `thresh`, or the check is disabled, no pulse is produced.
- R7: With `squelch_en` high and `cca` low, `rx_data_out` holds its last value. In every other case `rx_data_out` follows `rx_data_raw` with one register of delay.
- R8: At the first edge with `rx_on` low, `cca`, `cca_latched` and `irq_flag` go low. While `rx_on` is low, strobes raise none of them, nor `inv_preamble`.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_on | input | 1 | Receiver enabled |
| thresh | input | RSSI_W | Programmable strength threshold |
| cur_rssi | input | RSSI_W | Current strength sample |
| cur_stb | input | 1 | Per-bit-period update strobe for `cur_rssi` |
| lat_rssi | input | RSSI_W | Latched strength sample |
| lat_stb | input | 1 | Latch event strobe for `lat_rssi` |
| sync_det | input | 1 | Sync word detected pulse |
| rx_restart | input | 1 | Receiver restart pulse |
| irq_clr | input | 1 | Host interrupt clear pulse |
| chk_at_latch_en | input | 1 | Enable weak-channel check at latch event |
| squelch_en | input | 1 | Enable data squelch |
| rx_data_raw | input | DATA_W | Raw demodulated data |
| irq_flag | output | 1 | Sticky strength interrupt |
| cca | output | 1 | Live clear-channel indication |
| cca_latched | output | 1 | Remembered clear-channel indication |
| inv_preamble | output | 1 | One-cycle invalid-preamble / timeout request |
| rx_data_out | output | DATA_W | Squelched receive data |

## Verification
The assertions assume the following about the inputs:
- `thresh` stays constant while samples are being compared.
- Strobes and the sync, restart and clear controls are single-cycle pulses, and all inputs are synchronous to `clk`.
- `rx_on` is only toggled between scenarios.

The directed stimulus keeps within these limits. It changes the threshold and enables only while no strobe is pending. It drives every pulse for exactly one clock. It places deliberate collisions, such as clear versus set or sync versus an above-threshold sample, in a single chosen cycle.

// File: rtl/rssi_evt_pkg.sv
package rssi_evt_pkg;
   typedef enum logic [0:0] {
      SQ_HOLD = 1'b0,
      SQ_ZERO = 1'b1
   } sq_mode_e;

   localparam int unsigned RSSI_W_MIN = 2;
   localparam int unsigned RSSI_W_MAX = 16;
endpackage

// File: rtl/rssi_evt_cmp.sv
module rssi_evt_cmp #(
   parameter int unsigned RSSI_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_on,
   input  logic [RSSI_W-1:0] thresh,
   input  logic [RSSI_W-1:0] cur_rssi,
   input  logic              cur_stb,
   output logic              above_q,
   output logic              new_above
);
   logic above_now;

   assign above_now = cur_rssi > thresh;
   assign new_above = rx_on & cur_stb & above_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       above_q <= 1'b0;
      else if (!rx_on)  above_q <= 1'b0;
      else if (cur_stb) above_q <= above_now;
   end

   p_cca_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_on && cur_stb) |=> (above_q == ($past(cur_rssi) > $past(thresh))));
   p_cca_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_on && !cur_stb) |=> $stable(above_q));
endmodule

// File: rtl/rssi_evt_flags.sv
module rssi_evt_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_on,
   input  logic new_above,
   input  logic irq_clr,
   input  logic sync_det,
   input  logic rx_restart,
   output logic irq_q,
   output logic ccal_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     irq_q <= 1'b0;
      else if (!rx_on)                irq_q <= 1'b0;
      else if (new_above)             irq_q <= 1'b1;
      else if (irq_clr || rx_restart) irq_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       ccal_q <= 1'b0;
      else if (!rx_on)                  ccal_q <= 1'b0;
      else if (sync_det || rx_restart)  ccal_q <= 1'b0;
      else if (new_above)               ccal_q <= 1'b1;
   end

   p_irq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      new_above |=> irq_q);
   p_irq_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && rx_on && !irq_clr && !rx_restart) |=> irq_q);
   p_ccal_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_det || rx_restart) |=> !ccal_q);
   p_ccal_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ccal_q && rx_on && !sync_det && !rx_restart) |=> ccal_q);
   p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_on |=> (!irq_q && !ccal_q));
endmodule

// File: rtl/rssi_evt_latchk.sv
module rssi_evt_latchk #(
   parameter int unsigned RSSI_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_on,
   input  logic              chk_en,
   input  logic [RSSI_W-1:0] thresh,
   input  logic [RSSI_W-1:0] lat_rssi,
   input  logic              lat_stb,
   output logic              weak_q
);
   logic weak_now;

   assign weak_now = rx_on & chk_en & lat_stb & (lat_rssi < thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) weak_q <= 1'b0;
      else        weak_q <= weak_now;
   end

   p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_on && chk_en && lat_stb && (lat_rssi < thresh)) |=> !weak_q);
   p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_on && chk_en && lat_stb && (lat_rssi < thresh)) |=> weak_q);
endmodule

// File: rtl/rssi_evt_squelch.sv
module rssi_evt_squelch
   import rssi_evt_pkg::*;
#(
   parameter int unsigned DATA_W  = 1,
   parameter sq_mode_e    SQ_MODE = SQ_HOLD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              squelch_en,
   input  logic              open_q,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   logic gate;

   assign gate = squelch_en & ~open_q;

   generate
      if (SQ_MODE == SQ_HOLD) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     dout <= '0;
            else if (!gate) dout <= din;
         end
         p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            gate |=> $stable(dout));
      end else begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    dout <= '0;
            else if (gate) dout <= '0;
            else           dout <= din;
         end
         p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            gate |=> (dout == '0));
      end
   endgenerate

   p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !gate |=> (dout == $past(din)));
endmodule

// File: rtl/rssi_event_gen.sv
module rssi_event_gen
   import rssi_evt_pkg::*;
#(
   parameter int unsigned RSSI_W  = 8,
   parameter int unsigned DATA_W  = 1,
   parameter sq_mode_e    SQ_MODE = SQ_HOLD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_on,
   input  logic [RSSI_W-1:0] thresh,
   input  logic [RSSI_W-1:0] cur_rssi,
   input  logic              cur_stb,
   input  logic [RSSI_W-1:0] lat_rssi,
   input  logic              lat_stb,
   input  logic              sync_det,
   input  logic              rx_restart,
   input  logic              irq_clr,
   input  logic              chk_at_latch_en,
   input  logic              squelch_en,
   input  logic [DATA_W-1:0] rx_data_raw,
   output logic              irq_flag,
   output logic              cca,
   output logic              cca_latched,
   output logic              inv_preamble,
   output logic [DATA_W-1:0] rx_data_out
);
   generate
      if (RSSI_W < RSSI_W_MIN || RSSI_W > RSSI_W_MAX) begin : g_bad_rssi_w
         $error("rssi_event_gen: RSSI_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("rssi_event_gen: DATA_W must be at least 1");
      end
   endgenerate

   logic above_q;
   logic new_above;

   rssi_evt_cmp #(.RSSI_W(RSSI_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_on     (rx_on),
      .thresh    (thresh),
      .cur_rssi  (cur_rssi),
      .cur_stb   (cur_stb),
      .above_q   (above_q),
      .new_above (new_above)
   );

   rssi_evt_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_on      (rx_on),
      .new_above  (new_above),
      .irq_clr    (irq_clr),
      .sync_det   (sync_det),
      .rx_restart (rx_restart),
      .irq_q      (irq_flag),
      .ccal_q     (cca_latched)
   );

   rssi_evt_latchk #(.RSSI_W(RSSI_W)) u_latchk (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_on    (rx_on),
      .chk_en   (chk_at_latch_en),
      .thresh   (thresh),
      .lat_rssi (lat_rssi),
      .lat_stb  (lat_stb),
      .weak_q   (inv_preamble)
   );

   rssi_evt_squelch #(.DATA_W(DATA_W), .SQ_MODE(SQ_MODE)) u_sq (
      .clk        (clk),
      .rst_n      (rst_n),
      .squelch_en (squelch_en),
      .open_q     (above_q),
      .din        (rx_data_raw),
      .dout       (rx_data_out)
   );

   assign cca = above_q;

   p_cca_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_on |=> (!cca && !cca_latched && !irq_flag && !inv_preamble));
   p_ccal_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cca) && !$past(sync_det) && !$past(rx_restart)) |-> cca_latched);
endmodule

// File: tb/rssi_event_gen_test.sv
module rssi_event_gen_test;
   localparam int W  = 8;
   localparam int DW = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_on = 1'b0;
   logic [W-1:0]  thresh = '0;
   logic [W-1:0]  cur_rssi = '0;
   logic          cur_stb = 1'b0;
   logic [W-1:0]  lat_rssi = '0;
   logic          lat_stb = 1'b0;
   logic          sync_det = 1'b0;
   logic          rx_restart = 1'b0;
   logic          irq_clr = 1'b0;
   logic          chk_at_latch_en = 1'b0;
   logic          squelch_en = 1'b0;
   logic [DW-1:0] rx_data_raw = '0;
   logic          irq_flag, cca, cca_latched, inv_preamble;
   logic [DW-1:0] rx_data_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   rssi_event_gen #(.RSSI_W(W), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .thresh(thresh),
      .cur_rssi(cur_rssi), .cur_stb(cur_stb), .lat_rssi(lat_rssi),
      .lat_stb(lat_stb), .sync_det(sync_det), .rx_restart(rx_restart),
      .irq_clr(irq_clr), .chk_at_latch_en(chk_at_latch_en),
      .squelch_en(squelch_en), .rx_data_raw(rx_data_raw),
      .irq_flag(irq_flag), .cca(cca), .cca_latched(cca_latched),
      .inv_preamble(inv_preamble), .rx_data_out(rx_data_out)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic sample(input logic [W-1:0] v);
      cur_rssi = v; cur_stb = 1'b1;
      step();
      cur_stb = 1'b0;
   endtask

   task automatic clear_all();
      rx_restart = 1'b1; irq_clr = 1'b1;
      step();
      rx_restart = 1'b0; irq_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk(irq_flag, 0, "R9 irq after reset");
      chk(cca, 0, "R9 cca after reset");
      chk(cca_latched, 0, "R9 cca_latched after reset");
      chk(inv_preamble, 0, "R9 inv_preamble after reset");
      chk(rx_data_out, 0, "R9 data after reset");
   endtask

   task automatic t_cca();
      thresh = 8'd100;
      sample(8'd150); chk(cca, 1, "R1 above");
      sample(8'd100); chk(cca, 0, "R1 equal counts below");
      sample(8'd101); chk(cca, 1, "R1 one above");
      cur_rssi = 8'd0;
      step(); step(); step();
      chk(cca, 1, "R2 hold between strobes");
      sample(8'd20); chk(cca, 0, "R1 below");
   endtask

   task automatic t_irq();
      clear_all();
      chk(irq_flag, 0, "R4 cleared by restart+clr");
      chk_at_latch_en = 1'b1; lat_rssi = 8'd0;
      sample(8'd150); chk(irq_flag, 1, "R3 set with check-at-latch on");
      sample(8'd10);  step(); chk(irq_flag, 1, "R4 sticky");
      irq_clr = 1'b1; step(); irq_clr = 1'b0;
      chk(irq_flag, 0, "R4 host clear");
      irq_clr = 1'b1; sample(8'd150); irq_clr = 1'b0;
      chk(irq_flag, 1, "R4 set beats clear");
      rx_restart = 1'b1; step(); rx_restart = 1'b0;
      chk(irq_flag, 0, "R4 restart clears");
      chk_at_latch_en = 1'b0;
   endtask

   task automatic t_ccal();
      clear_all();
      sample(8'd150); chk(cca_latched, 1, "R5 set");
      sample(8'd10);  chk(cca_latched, 1, "R5 kept after cca low");
      irq_clr = 1'b1; step(); irq_clr = 1'b0;
      chk(cca_latched, 1, "R5 irq_clr ignored");
      sync_det = 1'b1; step(); sync_det = 1'b0;
      chk(cca_latched, 0, "R5 sync clears");
      sample(8'd150);
      rx_restart = 1'b1; step(); rx_restart = 1'b0;
      chk(cca_latched, 0, "R5 restart clears");
      sync_det = 1'b1; sample(8'd160); sync_det = 1'b0;
      chk(cca_latched, 0, "R5 sync wins over set");
      chk(cca, 1, "R1 cca still live");
   endtask

   task automatic t_latch();
      thresh = 8'd100; chk_at_latch_en = 1'b1;
      lat_rssi = 8'd50; lat_stb = 1'b1; step(); lat_stb = 1'b0;
      chk(inv_preamble, 1, "R6 weak pulse");
      step(); chk(inv_preamble, 0, "R6 single cycle");
      lat_rssi = 8'd100; lat_stb = 1'b1; step(); lat_stb = 1'b0;
      chk(inv_preamble, 0, "R6 equal passes");
      lat_rssi = 8'd200; lat_stb = 1'b1; step(); lat_stb = 1'b0;
      chk(inv_preamble, 0, "R6 strong passes");
      chk_at_latch_en = 1'b0;
      lat_rssi = 8'd50; lat_stb = 1'b1; step(); lat_stb = 1'b0;
      chk(inv_preamble, 0, "R6 disabled");
   endtask

   task automatic t_squelch();
      sample(8'd10);
      squelch_en = 1'b0; rx_data_raw = 1'b0; step();
      chk(rx_data_out, 0, "R7 pass when disabled");
      squelch_en = 1'b1;
      rx_data_raw = 1'b1; step(); chk(rx_data_out, 0, "R7 held");
      rx_data_raw = 1'b0; step(); rx_data_raw = 1'b1; step();
      chk(rx_data_out, 0, "R7 still held");
      sample(8'd150);
      rx_data_raw = 1'b1; step(); chk(rx_data_out, 1, "R7 open passes 1");
      rx_data_raw = 1'b0; step(); chk(rx_data_out, 0, "R7 open passes 0");
      sample(8'd10);
      squelch_en = 1'b0; rx_data_raw = 1'b1; step();
      chk(rx_data_out, 1, "R7 pass below when disabled");
   endtask

   task automatic t_off();
      clear_all();
      sample(8'd150);
      chk(irq_flag & cca & cca_latched, 1, "R8 precondition set");
      rx_on = 1'b0; step();
      chk(cca, 0, "R8 cca off"); chk(irq_flag, 0, "R8 irq off");
      chk(cca_latched, 0, "R8 latched off");
      chk_at_latch_en = 1'b1; lat_rssi = 8'd0; lat_stb = 1'b1;
      sample(8'd200); lat_stb = 1'b0;
      chk(cca, 0, "R8 no cca while off");
      chk(irq_flag, 0, "R8 no irq while off");
      chk(inv_preamble, 0, "R8 no inv_preamble while off");
      chk_at_latch_en = 1'b0; rx_on = 1'b1;
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      rx_on = 1'b1;
      step();
      t_cca();
      t_irq();
      t_ccal();
      t_latch();
      t_squelch();
      t_off();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule